// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block watches the instruction completion events that a processor pipeline reports and raises a debug request after a programmed number of them. A completion is either a retirement or a trap taken on an instruction. Every trap counts. This includes a fault whose instruction the handler later retries, and an illegal instruction that software emulates and that never retires. The block makes no attempt to tell these cases apart.

Software programs the remaining count, an enable and three privilege-mode qualifiers through one register write port. While the trigger is armed, each qualifying instruction lowers the count by one. When the instruction that finds the count at 1 completes, the block pulses `trig_fire` for one cycle and the count drops to 0. Writing a count of 1 therefore gives single-step behaviour to a debugger that has no debug-mode register access.

Top module: `icnt_trig`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `trig_enable` = 0, `trig_count` = 0 and `trig_fire` = 0.
- R2: A qualifying retirement with the count above 1 lowers `trig_count` by exactly 1, one cycle later, and leaves `trig_fire` low.
- R3: A qualifying trap (`ev_trap` = 1, `ev_retire` = 0) changes the count and fire output exactly as a retirement would.
- R4: `ev_retire` and `ev_trap` high in the same cycle are one event: the count drops by at most 1 and fire pulses at most once.
- R5: A qualifying event with the count at 1 sets `trig_fire` high in the next cycle and sets `trig_count` to 0.
- R6: With the enable cleared or the count at 0, events change neither `trig_count` nor `trig_fire`.
- R7: An event qualifies only if the enable bit for its privilege code is set. The codes are 2'b11 machine (`cfg_wr_m`), 2'b01 supervisor (`cfg_wr_s`) and 2'b00 user (`cfg_wr_u`).
- R8: A write (`cfg_we` = 1) in the same cycle as a qualifying event loads the written count and qualifiers. It applies no decrement and produces no fire.
- R9: `trig_fire` is never high for two cycles in a row. After a fire, the count stays at 0 until it is rewritten.
- R10: Privilege code 2'b10 is reserved and never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for all configuration fields |
| cfg_wr_enable | input | 1 | Enable value to write |
| cfg_wr_m | input | 1 | Machine-mode qualifier to write |
| cfg_wr_s | input | 1 | Supervisor-mode qualifier to write |
| cfg_wr_u | input | 1 | User-mode qualifier to write |
| cfg_wr_count | input | CNT_W | Count value to write |
| ev_retire | input | 1 | An instruction retired this cycle |
| ev_trap | input | 1 | A trap was taken on an instruction this cycle |
| ev_priv | input | 2 | Privilege code that the reported instruction ran in |
| trig_fire | output | 1 | One-cycle debug request |
| trig_count | output | CNT_W | Current remaining count |
| trig_enable | output | 1 | Current enable bit |

## Verification
Every result is registered once. A write or an event presented before a rising edge shows up on `trig_count`, `trig_enable` and `trig_fire` right after that edge, and `trig_fire` falls again one edge later. The bench drives inputs on falling edges and samples on the falling edge that follows the update. It therefore reads the count and fire one cycle after each event, and reads fire once more a cycle later to confirm the pulse has ended. The sweep covers every privilege code, every qualifier mask, both enable values, all four retire/trap combinations and several start counts. The expected count and fire values are computed arithmetically from the requirements.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  localparam int NUM_PRIV = 4;

  typedef struct packed {
    logic enable;
    logic allow_m;
    logic allow_s;
    logic allow_u;
  } qual_cfg_t;

  // Qualifier vector indexed by privilege code; the reserved code stays 0.
  function automatic logic [NUM_PRIV-1:0] allow_vec(input qual_cfg_t c);
    logic [NUM_PRIV-1:0] v;
    v                 = '0;
    v[int'(PRIV_U)]   = c.allow_u;
    v[int'(PRIV_S)]   = c.allow_s;
    v[int'(PRIV_M)]   = c.allow_m;
    return v;
  endfunction

endpackage

// File: rtl/icnt_cfg_regs.sv
module icnt_cfg_regs
  import icnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  qual_cfg_t wr_cfg,
  output qual_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= wr_cfg;
    end
  end

  AST_CFG_RESET: assert property (@(posedge clk) rst |=> !cfg_q.enable); // R1

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> cfg_q == $past(wr_cfg)); // R8

endmodule

// File: rtl/icnt_event_qual.sv
module icnt_event_qual
  import icnt_pkg::*;
(
  input  qual_cfg_t  cfg,
  input  logic       retire,
  input  logic       trap,
  input  logic [1:0] priv,
  input  logic       count_nz,
  output logic       hit
);

  logic [NUM_PRIV-1:0] allow;
  logic [NUM_PRIV-1:0] priv_hit;
  logic                completion;

  assign allow = allow_vec(cfg);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PRIV; gi++) begin : g_mode
      assign priv_hit[gi] = allow[gi] && (priv == gi[1:0]);
    end
  endgenerate

  // Retire and trap for one instruction merge into a single completion.
  assign completion = retire | trap;
  assign hit        = completion && cfg.enable && count_nz && (|priv_hit);

  always_comb begin
    AST_SINGLE_MODE: assert ($countones(priv_hit) <= 1); // R7
  end

endmodule

// File: rtl/icnt_count_core.sv
module icnt_count_core #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             we,
  input  logic [CNT_W-1:0] wr_count,
  output logic [CNT_W-1:0] count_q,
  output logic             fire_q,
  output logic             count_nz
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last_one;

  assign count_nz = |count_q;
  assign last_one = (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      fire_q  <= 1'b0;
    end else if (we) begin
      count_q <= wr_count;
      fire_q  <= 1'b0;
    end else if (hit) begin
      count_q <= last_one ? '0 : count_q - ONE;
      fire_q  <= last_one;
    end else begin
      fire_q  <= 1'b0;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count_q == '0) && !fire_q); // R1

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (hit && !we && count_q > ONE) |=> (count_q == $past(count_q) - ONE) && !fire_q); // R2

  AST_FIRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> count_q == '0); // R5

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    we |=> (count_q == $past(wr_count)) && !fire_q); // R8

endmodule

// File: rtl/icnt_trig.sv
module icnt_trig
  import icnt_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_wr_enable,
  input  logic             cfg_wr_m,
  input  logic             cfg_wr_s,
  input  logic             cfg_wr_u,
  input  logic [CNT_W-1:0] cfg_wr_count,
  input  logic             ev_retire,
  input  logic             ev_trap,
  input  logic [1:0]       ev_priv,
  output logic             trig_fire,
  output logic [CNT_W-1:0] trig_count,
  output logic             trig_enable
);

  qual_cfg_t wr_cfg;
  qual_cfg_t cfg_q;
  logic      hit;
  logic      count_nz;

  assign wr_cfg.enable  = cfg_wr_enable;
  assign wr_cfg.allow_m = cfg_wr_m;
  assign wr_cfg.allow_s = cfg_wr_s;
  assign wr_cfg.allow_u = cfg_wr_u;

  icnt_cfg_regs u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  icnt_event_qual u_qual (
    .cfg      (cfg_q),
    .retire   (ev_retire),
    .trap     (ev_trap),
    .priv     (ev_priv),
    .count_nz (count_nz),
    .hit      (hit)
  );

  icnt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .we       (cfg_we),
    .wr_count (cfg_wr_count),
    .count_q  (trig_count),
    .fire_q   (trig_fire),
    .count_nz (count_nz)
  );

  assign trig_enable = cfg_q.enable;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((!trig_enable || trig_count == '0) && !cfg_we) |=> $stable(trig_count) && !trig_fire); // R6

  AST_PRIV_RSVD: assert property (@(posedge clk) disable iff (rst)
    ((ev_priv == 2'b10) && !cfg_we) |=> $stable(trig_count) && !trig_fire); // R10

  AST_ONE_PER_INSTR: assert property (@(posedge clk) disable iff (rst)
    (ev_retire && ev_trap && !cfg_we && trig_count > CNT_W'(1)) |=>
      (trig_count == $past(trig_count)) || (trig_count == $past(trig_count) - CNT_W'(1))); // R4

  AST_TRAP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (ev_trap && !ev_retire && !cfg_we && trig_enable && ev_priv == 2'b11 &&
     cfg_q.allow_m && trig_count > CNT_W'(1)) |=> trig_count == $past(trig_count) - CNT_W'(1)); // R3

endmodule

// File: tb/icnt_trig_test.sv
`timescale 1ns/1ps
module icnt_trig_test;

  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_we, cfg_wr_enable, cfg_wr_m, cfg_wr_s, cfg_wr_u;
  logic [CNT_W-1:0] cfg_wr_count;
  logic             ev_retire, ev_trap;
  logic [1:0]       ev_priv;
  logic             trig_fire, trig_enable;
  logic [CNT_W-1:0] trig_count;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  icnt_trig #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wr_enable(cfg_wr_enable),
    .cfg_wr_m(cfg_wr_m), .cfg_wr_s(cfg_wr_s), .cfg_wr_u(cfg_wr_u),
    .cfg_wr_count(cfg_wr_count), .ev_retire(ev_retire), .ev_trap(ev_trap),
    .ev_priv(ev_priv), .trig_fire(trig_fire), .trig_count(trig_count),
    .trig_enable(trig_enable)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_wr_enable = 0; cfg_wr_m = 0; cfg_wr_s = 0; cfg_wr_u = 0;
    cfg_wr_count = '0; ev_retire = 0; ev_trap = 0; ev_priv = 2'b00;
  endtask

  // Write all fields; result visible at the following falling edge.
  task automatic write_cfg(input bit en, input bit m, input bit s, input bit u, input int cnt);
    cfg_we = 1; cfg_wr_enable = en; cfg_wr_m = m; cfg_wr_s = s; cfg_wr_u = u;
    cfg_wr_count = CNT_W'(cnt);
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic bit mode_ok(input int priv, input bit m, input bit s, input bit u);
    case (priv)
      3: return m;
      1: return s;
      0: return u;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 count", int'(trig_count), 0);
    check("R1 enable", int'(trig_enable), 0);
    check("R1 fire", int'(trig_fire), 0);

    // Near-exhaustive sweep.
    for (int priv = 0; priv < 4; priv++)
      for (int mask = 0; mask < 8; mask++)
        for (int en = 0; en < 2; en++)
          for (int ev = 0; ev < 4; ev++)
            for (int ci = 0; ci < 5; ci++) begin
              int start, exp_cnt, exp_fire;
              bit m, s, u, r, t, hit;
              string tag;
              case (ci)
                0: start = 0;
                1: start = 1;
                2: start = 2;
                3: start = 3;
                default: start = CMAX;
              endcase
              m = mask[2]; s = mask[1]; u = mask[0];
              r = ev[0]; t = ev[1];
              write_cfg(en[0], m, s, u, start);
              ev_retire = r; ev_trap = t; ev_priv = 2'(priv);
              @(negedge clk);
              ev_retire = 0; ev_trap = 0;
              hit = en[0] && (start != 0) && (r || t) && mode_ok(priv, m, s, u);
              exp_cnt  = hit ? (start > 1 ? start - 1 : 0) : start;
              exp_fire = (hit && start == 1) ? 1 : 0;
              if (priv == 2)                     tag = "R10";
              else if (!en[0] || start == 0)     tag = "R6";
              else if (!mode_ok(priv, m, s, u))  tag = "R7";
              else if (r && t)                   tag = "R4";
              else if (t)                        tag = "R3";
              else if (start == 1)               tag = "R5";
              else                               tag = "R2";
              check({tag, " count"}, int'(trig_count), exp_cnt);
              check({tag, " fire"}, int'(trig_fire), exp_fire);
              @(negedge clk);
              if (exp_fire == 1)
                check("R9 fire drops", int'(trig_fire), 0);
            end

    // R9: after firing, further events leave count at 0 and no second fire.
    write_cfg(1, 1, 1, 1, 1);
    ev_retire = 1; ev_priv = 2'b11;
    @(negedge clk);
    check("R5 step fire", int'(trig_fire), 1);
    @(negedge clk);
    check("R9 no refire", int'(trig_fire), 0);
    check("R9 count held", int'(trig_count), 0);
    ev_retire = 0;

    // R8: write wins over a coinciding match.
    write_cfg(1, 1, 1, 1, 3);
    cfg_we = 1; cfg_wr_enable = 1; cfg_wr_m = 1; cfg_wr_s = 1; cfg_wr_u = 1;
    cfg_wr_count = CNT_W'(9); ev_trap = 1; ev_priv = 2'b00;
    @(negedge clk);
    cfg_we = 0; ev_trap = 0;
    check("R8 count loaded", int'(trig_count), 9);
    check("R8 no fire", int'(trig_fire), 0);
    write_cfg(1, 1, 1, 1, 1);
    cfg_we = 1; cfg_wr_count = CNT_W'(1); ev_retire = 1; ev_priv = 2'b01;
    @(negedge clk);
    cfg_we = 0;
    check("R8 count one kept", int'(trig_count), 1);
    check("R8 fire suppressed", int'(trig_fire), 0);
    @(negedge clk);
    ev_retire = 0;
    check("R5 fire after write", int'(trig_fire), 1);
    check("R5 count zero", int'(trig_count), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule